// File: doc/BRIEF.md
# Legacy System Control and Status Port

This block is a single 8-bit register that sits at a fixed I/O port address on a simple read/write bus. Its low four bits are software controls. One enables counting on interval-timer channel 2 and one lets that channel's output reach the speaker pin. The other two are level-held clear controls for two error latches. The upper four bits are read-only status: the live timer-2 output, a refresh toggle that flips at the timer-1 interval, and the two sticky error latches.

The first latch records an active-low system error pin. The second records an active-low I/O check pin, or a one-cycle error-message strobe from the host bus. Both pins pass through a two-flop synchronizer first. A registered NMI request is raised whenever either latch holds a set value and the NMI-disable input is low. The interval timer is outside the block and appears only as inputs.

Each error latch is a two-state machine. The states are `LAT_IDLE` and `LAT_HELD`. The transition *capture* goes from `LAT_IDLE` to `LAT_HELD` when a set event arrives and the clear control is 0. The transition *release* goes from `LAT_HELD` to `LAT_IDLE` whenever the clear control is 1. Otherwise each state holds. The latch's visible value is masked at once by its clear control, so a set clear bit reads as 0 without waiting a cycle.

Top module: `legacy_ctl_port`

## Requirements
- R1: After reset the port reads 00h in bits 7:6 and 3:0, and `timer2_gate`, `speaker` and `nmi_req` are 0.
- R2: `timer2_gate` equals control bit 0 (gate enable) from the clock edge that writes it.
- R3: `speaker` equals `timer2_out` while control bit 1 (speaker enable) is 1, and is 0 while it is 0.
- R4: A write whose address differs from `PORT_ADDR` (default 16'h0061) leaves the register unchanged.
- R5: Written values in bits 7:4 are ignored. Bits 3:0 read back as last written.
- R6: `sys_err_n` held low sets bit 7 on the third rising edge after it is first driven low. Bit 7 then stays 1 after the pin returns high, until it is cleared.
- R7: Bit 6 is set on the third rising edge after `io_chk_n` goes low, and also on the first rising edge after a one-cycle `bus_err_msg` pulse.
- R8: While bit 2 is 1, bit 7 reads 0; while bit 3 is 1, bit 6 reads 0. This holds even when a set event arrives in the same cycle (clear wins).
- R9: Bit 5 reads `timer2_out` and bit 4 reads `refresh_tog` combinationally.
- R10: `nmi_req` is registered: one edge after (bit 7 OR bit 6) AND NOT `nmi_mask` holds, it shows that value.
- R11: `io_rdata` is 00h unless `io_rd` is 1 and `io_addr` equals `PORT_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | ADDR_W | I/O port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| timer2_out | input | 1 | Output of interval-timer channel 2 |
| refresh_tog | input | 1 | Refresh-interval toggle |
| sys_err_n | input | 1 | Active-low system error pin |
| io_chk_n | input | 1 | Active-low I/O check pin |
| bus_err_msg | input | 1 | One-cycle error-message strobe from the host bus |
| nmi_mask | input | 1 | NMI disable |
| timer2_gate | output | 1 | Count enable for timer channel 2 |
| speaker | output | 1 | Speaker drive |
| nmi_req | output | 1 | Registered NMI request, active high |

## Verification
All 256 write values are swept against all four combinations of the timer-2 output and refresh toggle. This separates stored control bits from live status bits, and shows that writes to the upper nibble have no effect. It also tests the speaker gating in both polarities.

Error stimulus comes from each pin alone, from the bus strobe alone, and from each source with its clear bit held. These runs separate synchronizer latency from latch stickiness and check the clear-over-set priority. Toggling the NMI disable with a latch set shows that the request depends on the mask and is one cycle late.

// File: rtl/legacy_ctl_port_pkg.sv
package legacy_ctl_port_pkg;
    localparam int BYTE_W = 8;
    // control bit positions (software visible)
    localparam int B_GATE   = 0;
    localparam int B_SPK    = 1;
    localparam int B_CLRSE  = 2;
    localparam int B_CLRIC  = 3;
    // status bit positions
    localparam int B_REFR   = 4;
    localparam int B_T2     = 5;
    localparam int B_IOCHK  = 6;
    localparam int B_SERR   = 7;
    localparam int CTL_W    = 4;

    typedef enum logic {
        LAT_IDLE = 1'b0,
        LAT_HELD = 1'b1
    } lat_state_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/err_latch.sv
module err_latch
    import legacy_ctl_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    lat_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LAT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAT_IDLE: if (!clr_i && set_i) state_d = LAT_HELD;
            LAT_HELD: if (clr_i)           state_d = LAT_IDLE;
            default:                       state_d = LAT_IDLE;
        endcase
    end

    // clear masks the visible value at once
    always_comb begin
        flag_o = (state_q == LAT_HELD) && !clr_i;
    end
endmodule

// File: rtl/legacy_ctl_port.sv
module legacy_ctl_port
    import legacy_ctl_port_pkg::*;
#(
    parameter int               ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR  = 16'h0061,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              timer2_out,
    input  logic              refresh_tog,
    input  logic              sys_err_n,
    input  logic              io_chk_n,
    input  logic              bus_err_msg,
    input  logic              nmi_mask,
    output logic              timer2_gate,
    output logic              speaker,
    output logic              nmi_req
);
    logic             addr_hit;
    logic [CTL_W-1:0] ctl_q;
    logic             serr_pin_s, iochk_pin_s;
    logic             serr_seen, iochk_seen;
    logic [7:0]       port_val;

    assign addr_hit = (io_addr == PORT_ADDR);

    // control nibble: only bits 3:0 are stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ctl_q <= '0;
        else if (io_wr && addr_hit)  ctl_q <= io_wdata[CTL_W-1:0];
    end

    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_serr (
        .clk(clk), .rst_n(rst_n), .d_i(sys_err_n), .q_o(serr_pin_s)
    );
    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_iochk (
        .clk(clk), .rst_n(rst_n), .d_i(io_chk_n), .q_o(iochk_pin_s)
    );

    err_latch u_lat_serr (
        .clk(clk), .rst_n(rst_n),
        .set_i(!serr_pin_s), .clr_i(ctl_q[B_CLRSE]), .flag_o(serr_seen)
    );
    err_latch u_lat_iochk (
        .clk(clk), .rst_n(rst_n),
        .set_i(!iochk_pin_s || bus_err_msg), .clr_i(ctl_q[B_CLRIC]), .flag_o(iochk_seen)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nmi_req <= 1'b0;
        else        nmi_req <= (serr_seen || iochk_seen) && !nmi_mask;
    end

    always_comb begin
        port_val          = '0;
        port_val[CTL_W-1:0] = ctl_q;
        port_val[B_REFR]  = refresh_tog;
        port_val[B_T2]    = timer2_out;
        port_val[B_IOCHK] = iochk_seen;
        port_val[B_SERR]  = serr_seen;
    end

    assign io_rdata    = (io_rd && addr_hit) ? port_val : 8'h00;
    assign timer2_gate = ctl_q[B_GATE];
    assign speaker     = ctl_q[B_SPK] && timer2_out;
endmodule

// File: rtl/legacy_ctl_port_chk.sv
module legacy_ctl_port_chk #(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0061
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              bus_err_msg,
    input logic              nmi_mask,
    input logic              timer2_gate,
    input logic              speaker,
    input logic              nmi_req,
    input logic              serr_seen,
    input logic              iochk_seen
);
    logic hit_wr;
    assign hit_wr = io_wr && (io_addr == PORT_ADDR);

    p_gate_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_wr |=> timer2_gate == $past(io_wdata[0]));

    p_spk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == PORT_ADDR && !io_rdata[1]) |-> !speaker);

    p_serr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_seen && !(hit_wr && io_wdata[2])) |=> serr_seen);

    p_msg_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err_msg && !(io_rd && io_addr == PORT_ADDR && io_rdata[3] == 1'b1)
         && !hit_wr && io_rd && io_addr == PORT_ADDR) |=> iochk_seen);

    p_clr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && io_wdata[3]) |=> !iochk_seen);

    p_nmi_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> nmi_req == $past((serr_seen || iochk_seen) && !nmi_mask));

    p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == 8'h00);
endmodule

bind legacy_ctl_port legacy_ctl_port_chk #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .bus_err_msg(bus_err_msg),
    .nmi_mask(nmi_mask), .timer2_gate(timer2_gate), .speaker(speaker),
    .nmi_req(nmi_req), .serr_seen(serr_seen), .iochk_seen(iochk_seen)
);

// File: tb/legacy_ctl_port_test.sv
module legacy_ctl_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        timer2_out = 1'b0, refresh_tog = 1'b0;
    logic        sys_err_n = 1'b1, io_chk_n = 1'b1, bus_err_msg = 1'b0, nmi_mask = 1'b0;
    logic        timer2_gate, speaker, nmi_req;
    int          n_run = 0, n_fail = 0;
    logic [3:0]  ctl_exp = 4'h0;
    logic        done = 1'b0;

    localparam logic [15:0] PORT = 16'h0061;

    always #10 clk = ~clk;

    legacy_ctl_port uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .timer2_out(timer2_out),
        .refresh_tog(refresh_tog), .sys_err_n(sys_err_n), .io_chk_n(io_chk_n),
        .bus_err_msg(bus_err_msg), .nmi_mask(nmi_mask), .timer2_gate(timer2_gate),
        .speaker(speaker), .nmi_req(nmi_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (a == PORT) ctl_exp = d[3:0];
    endtask

    task automatic rd_port(input logic [15:0] a, output logic [7:0] d);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    function automatic logic [7:0] exp_byte(input logic se, input logic ic);
        return {se, ic, timer2_out, refresh_tog, ctl_exp};
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rd_port(PORT, r);
        chk("R1 reset read", r, 8'h00);
        chk("R1 reset outs", {5'b0, timer2_gate, speaker, nmi_req}, 8'h00);
        rst_n = 1'b1;

        // R5/R2/R3/R9: sweep every write value against status inputs
        for (int v = 0; v < 256; v++) begin
            wr_port(PORT, v[7:0]);
            for (int s = 0; s < 4; s++) begin
                timer2_out = s[0]; refresh_tog = s[1];
                rd_port(PORT, r);
                chk("R5 R9 readback", r, exp_byte(1'b0, 1'b0));
                chk("R2 gate", {7'b0, timer2_gate}, {7'b0, v[0]});
                chk("R3 speaker", {7'b0, speaker}, {7'b0, v[1] & s[0]});
            end
        end

        // R4: other address ignored
        wr_port(PORT, 8'h01);
        wr_port(16'h0060, 8'h0F);
        rd_port(PORT, r);
        chk("R4 other addr write", r, exp_byte(1'b0, 1'b0));
        // R11: read gating
        rd_port(16'h0060, r);
        chk("R11 other addr read", r, 8'h00);
        io_addr = PORT; #1 chk("R11 no rd strobe", io_rdata, 8'h00);

        // R6: system error pin
        wr_port(PORT, 8'h00);
        timer2_out = 0; refresh_tog = 0;
        @(negedge clk); sys_err_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rd_port(PORT, r);
        chk("R6 not before sync", r, 8'h00);
        @(negedge clk);
        rd_port(PORT, r);
        chk("R6 set after 3 edges", r, 8'h80);
        chk("R10 nmi not yet", {7'b0, nmi_req}, 8'h00);
        sys_err_n = 1'b1;
        @(negedge clk);
        chk("R10 nmi raised", {7'b0, nmi_req}, 8'h01);
        repeat (4) @(negedge clk);
        rd_port(PORT, r);
        chk("R6 sticky", r, 8'h80);
        nmi_mask = 1'b1;
        @(negedge clk);
        chk("R10 nmi masked", {7'b0, nmi_req}, 8'h00);
        nmi_mask = 1'b0;

        // R8: clear, and clear wins with pin low
        sys_err_n = 1'b0;
        wr_port(PORT, 8'h04);
        rd_port(PORT, r);
        chk("R8 serr cleared", r, 8'h04);
        repeat (4) @(negedge clk);
        rd_port(PORT, r);
        chk("R8 serr held clear", r, 8'h04);
        sys_err_n = 1'b1;
        repeat (3) @(negedge clk);
        wr_port(PORT, 8'h00);
        @(negedge clk);
        rd_port(PORT, r);
        chk("R8 released stays 0", r, 8'h00);
        chk("R10 nmi low", {7'b0, nmi_req}, 8'h00);

        // R7: bus message
        bus_err_msg = 1'b1;
        @(negedge clk); bus_err_msg = 1'b0;
        rd_port(PORT, r);
        chk("R7 msg sets iochk", r, 8'h40);
        wr_port(PORT, 8'h08);
        rd_port(PORT, r);
        chk("R8 iochk cleared", r, 8'h08);
        bus_err_msg = 1'b1;
        @(negedge clk); bus_err_msg = 1'b0;
        rd_port(PORT, r);
        chk("R8 clear beats msg", r, 8'h08);
        wr_port(PORT, 8'h00);
        rd_port(PORT, r);
        chk("R8 no late set", r, 8'h00);

        // R7: io check pin
        io_chk_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rd_port(PORT, r);
        chk("R7 pin not before sync", r, 8'h00);
        @(negedge clk);
        rd_port(PORT, r);
        chk("R7 pin sets iochk", r, 8'h40);
        io_chk_n = 1'b1;
        @(negedge clk);
        chk("R10 nmi from iochk", {7'b0, nmi_req}, 8'h01);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule